// File: doc/BRIEF.md
# Carry-Select Compound Adder

This is a purely combinational adder for two unsigned operands of equal width. In one pass it returns both the plain sum A+B and the incremented sum A+B+1, each with its carry-out. Rounding logic, for example, can then pick either result without a second addition.

The operands are cut into sub-blocks. Every sub-block adds its slice twice, once with carry-in 0 and once with carry-in 1. Two independent select chains then run across the blocks:

- The plain-sum chain enters the lowest block with carry 0.
- The incremented chain enters it with carry 1.

In each chain, the carry arriving at a block picks one of that block's two precomputed slices. The carry-out of the picked slice drives the select of the next block up.

A parameter sets the split. The default is one block spanning the whole width. The other mode uses 4-bit blocks and makes the lowest block narrower to absorb any remainder, so width 10 becomes 2, 4 and 4 bits counted from the LSB. The two operand widths are separate parameters, and elaboration stops if they differ.

Top module: `cs_compound_adder`

## Requirements
- R1: `sum_out` equals opa+opb as an unsigned WIDTH+1-bit value, with bit WIDTH holding the carry-out.
- R2: `inc_out` equals opa+opb+1 as an unsigned WIDTH+1-bit value, with bit WIDTH holding the carry-out.
- R3: With SPLIT_MODE=0 (the default), the operands form one block of full width, and R1 and R2 hold at widths 10 and 13.
- R4: With SPLIT_MODE=1, the blocks are 4 bits wide and the lowest block takes the remainder (width 10 gives 2, 4 and 4 bits from the LSB). Results stay correct when a carry crosses bit 2 and bit 6.
- R5: A carry entering the lowest block ripples through every block boundary. For width 10, 0x3FF+0x001 gives `sum_out`=0x400 and `inc_out`=0x401.
- R6: When opa+opb equals 2^WIDTH-1, the carry-out of `sum_out` is 0 and the carry-out of `inc_out` is 1.
- R7: With SPLIT_MODE=1 and a width that is a multiple of 4 (8 and 16), the lowest block is a full 4 bits and R1 and R2 hold.
- R8: A width of 1 in SPLIT_MODE=1 gives correct sums for all four operand pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | OPA_W | First unsigned operand |
| opb | input | OPB_W | Second unsigned operand, same width as opa |
| sum_out | output | OPA_W+1 | opa+opb, carry-out in the top bit |
| inc_out | output | OPA_W+1 | opa+opb+1, carry-out in the top bit |

## Verification
The case that matters most is when the two chains pick different slices in the same block. That happens when the plain sum is all ones in the low bits and the incremented sum carries across a block boundary, or out of the top. Directed operands provoke this:

- operand pairs whose sum is 2^WIDTH-1;
- pairs whose sum is all ones in the lowest block;
- all-ones operand pairs.

These run alongside random pairs. Both outputs are judged against native addition at widths that are and are not multiples of 4.

// File: rtl/cs_compound_adder.sv
module cs_compound_adder #(
  parameter int OPA_W      = 10,
  parameter int OPB_W      = 10,
  parameter int SPLIT_MODE = 0
) (
  input  logic [OPA_W-1:0] opa,
  input  logic [OPB_W-1:0] opb,
  output logic [OPA_W:0]   sum_out,
  output logic [OPA_W:0]   inc_out
);
  localparam int W     = OPA_W;
  localparam int NBLK  = (SPLIT_MODE == 0) ? 1 : (W + 3) / 4;
  localparam int LOW_W = W - 4 * (NBLK - 1);

  if (OPA_W != OPB_W) begin : g_width_check
    $error("cs_compound_adder: operand widths differ");
  end
  if (SPLIT_MODE != 0 && SPLIT_MODE != 1) begin : g_mode_check
    $error("cs_compound_adder: SPLIT_MODE must be 0 or 1");
  end

  logic [NBLK:0] csel0;
  logic [NBLK:0] csel1;
  logic [W-1:0]  sbits;
  logic [W-1:0]  ibits;

  assign csel0[0] = 1'b0;
  assign csel1[0] = 1'b1;

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    localparam int BW = (i == 0) ? LOW_W : 4;
    localparam int LO = (i == 0) ? 0 : LOW_W + 4 * (i - 1);
    logic [BW:0] pre0;
    logic [BW:0] pre1;
    assign pre0 = {1'b0, opa[LO +: BW]} + {1'b0, opb[LO +: BW]};
    assign pre1 = {1'b0, opa[LO +: BW]} + {1'b0, opb[LO +: BW]} + {{BW{1'b0}}, 1'b1};
    assign sbits[LO +: BW] = csel0[i] ? pre1[BW-1:0] : pre0[BW-1:0];
    assign ibits[LO +: BW] = csel1[i] ? pre1[BW-1:0] : pre0[BW-1:0];
    assign csel0[i+1] = csel0[i] ? pre1[BW] : pre0[BW];
    assign csel1[i+1] = csel1[i] ? pre1[BW] : pre0[BW];
  end

  assign sum_out = {csel0[NBLK], sbits};
  assign inc_out = {csel1[NBLK], ibits};

  always_comb begin
    if (!$isunknown({opa, opb})) begin
      a_r2_inc_follows_sum: assert (inc_out == sum_out + {{W{1'b0}}, 1'b1})
        else $error("R2: inc_out is not sum_out+1");
      a_r1_lsb_parity: assert (sum_out[0] == (opa[0] ^ opb[0]))
        else $error("R1: sum_out bit 0 wrong");
      a_r2_lsb_parity: assert (inc_out[0] == ~(opa[0] ^ opb[0]))
        else $error("R2: inc_out bit 0 wrong");
      a_r6_cout_order: assert (!sum_out[W] || inc_out[W])
        else $error("R6: sum carry set without inc carry");
      if (&(opa ^ opb[W-1:0]) == 1'b1) begin
        a_r6_all_ones_edge: assert (!sum_out[W] && inc_out[W] && (&sum_out[W-1:0]))
          else $error("R6: all-ones sum edge wrong");
      end
    end
  end
endmodule

// File: tb/cs_compound_adder_tb.sv
module cs_compound_adder_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [63:0] a_drv, b_drv;

  logic [10:0] s10, i10, s10s, i10s;
  logic [13:0] s13, i13;
  logic [8:0]  s8, i8;
  logic [16:0] s16, i16;
  logic [1:0]  s1, i1;

  cs_compound_adder #(.OPA_W(10), .OPB_W(10), .SPLIT_MODE(1)) u_dut
    (.opa(a_drv[9:0]), .opb(b_drv[9:0]), .sum_out(s10), .inc_out(i10));
  cs_compound_adder #(.OPA_W(10), .OPB_W(10)) u_single10
    (.opa(a_drv[9:0]), .opb(b_drv[9:0]), .sum_out(s10s), .inc_out(i10s));
  cs_compound_adder #(.OPA_W(13), .OPB_W(13), .SPLIT_MODE(0)) u_single13
    (.opa(a_drv[12:0]), .opb(b_drv[12:0]), .sum_out(s13), .inc_out(i13));
  cs_compound_adder #(.OPA_W(8), .OPB_W(8), .SPLIT_MODE(1)) u_w8
    (.opa(a_drv[7:0]), .opb(b_drv[7:0]), .sum_out(s8), .inc_out(i8));
  cs_compound_adder #(.OPA_W(16), .OPB_W(16), .SPLIT_MODE(1)) u_w16
    (.opa(a_drv[15:0]), .opb(b_drv[15:0]), .sum_out(s16), .inc_out(i16));
  cs_compound_adder #(.OPA_W(1), .OPB_W(1), .SPLIT_MODE(1)) u_w1
    (.opa(a_drv[0]), .opb(b_drv[0]), .sum_out(s1), .inc_out(i1));

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  function automatic longint unsigned msk(int w, longint unsigned v);
    return v & ((64'd1 << w) - 64'd1);
  endfunction

  task automatic chk(string tag, int w, longint unsigned gs, longint unsigned gi);
    longint unsigned ea, eb, es, ei;
    ea = msk(w, a_drv);
    eb = msk(w, b_drv);
    es = ea + eb;
    ei = ea + eb + 64'd1;
    checks++;
    if (gs != es || gi != ei) begin
      errors++;
      $display("FAIL %s w=%0d a=%0h b=%0h sum=%0h exp %0h inc=%0h exp %0h",
               tag, w, ea, eb, gs, es, gi, ei);
    end
  endtask

  task automatic apply(longint unsigned a, longint unsigned b);
    @(posedge clk);
    a_drv = a;
    b_drv = b;
    @(negedge clk);
  endtask

  task automatic check_all(string tag);
    chk({tag, " R4 R1 R2"}, 10, 64'(s10), 64'(i10));
    chk({tag, " R3"}, 10, 64'(s10s), 64'(i10s));
    chk({tag, " R3"}, 13, 64'(s13), 64'(i13));
    chk({tag, " R7"}, 8, 64'(s8), 64'(i8));
    chk({tag, " R7"}, 16, 64'(s16), 64'(i16));
    chk({tag, " R8"}, 1, 64'(s1), 64'(i1));
  endtask

  initial begin
    a_drv = '0;
    b_drv = '0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("zero inputs");
    apply(64'h3FF, 64'h001);
    checks++;
    if (s10 != 11'h400 || i10 != 11'h401) begin
      errors++;
      $display("FAIL R5 sum=%0h exp 400 inc=%0h exp 401", s10, i10);
    end
    check_all("R5 ripple");
    apply(64'h200, 64'h1FF);
    checks++;
    if (s10[10] != 1'b0 || i10[10] != 1'b1) begin
      errors++;
      $display("FAIL R6 sum_cout=%0b exp 0 inc_cout=%0b exp 1", s10[10], i10[10]);
    end
    check_all("R6 edge");
    apply(64'h3, 64'h1);
    check_all("R4 bit2 cross");
    apply(64'h3C, 64'h4);
    check_all("R4 bit6 cross");
    apply(64'hFFFF, 64'hFFFF);
    check_all("all ones");
    apply(64'hFFFF, 64'h0);
    check_all("R6 ones plus zero");
    for (int k = 0; k < 4; k++) begin
      apply(64'(k & 1), 64'(k >> 1));
      check_all("R8 width1 sweep");
    end
    void'($urandom(32'd12345));
    for (int n = 0; n < 3000; n++) begin
      apply({$urandom(), $urandom()}, {$urandom(), $urandom()});
      check_all("random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1 actual=%0d cycles expected<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule